// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address and the written-back base for a single-register load or store. It takes the base register, an offset, and four control flags. The offset is either a 12-bit unsigned immediate or a second register passed through an immediate-amount shifter. An up/down flag picks whether the offset is added to the base or taken from it. A pre/post flag picks whether the transfer uses the adjusted base or the original base. A writeback flag and a privilege flag decide whether the base register is updated and whether the memory access must be forced to non-privileged mode.

Results are captured in an output register on each cycle where `in_valid` is high, and `out_valid` marks them one cycle later. The register file, the memory port and the rest of instruction decode sit outside the block.

Top module: `lsag_top`

## Requirements
- R1: With `use_reg`=0 the offset is `imm_off` zero-extended to 32 bits.
- R2: With `up`=1 the adjusted base is base + offset; with `up`=0 it is base − offset, both modulo 2^32 with no overflow indication.
- R3: With `pre`=1 `xfer_addr` is the adjusted base; with `pre`=0 `xfer_addr` is the unmodified base.
- R4: With `pre`=1 and `wb`=1, `wb_en`=1 and `new_base` is the adjusted base. With `pre`=1 and `wb`=0, `wb_en`=0 and `new_base` equals the unmodified base.
- R5: With `pre`=0, `wb_en`=1 and `new_base` is the adjusted base, whatever `wb` is.
- R6: `force_user` is 1 exactly when `pre`=0, `wb`=1 and `priv`=1.
- R7: With `use_reg`=1 the offset is `reg_off` shifted by `shift_ctl[6:2]` (amount 1..31) using the kind in `shift_ctl[1:0]`: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R8: A shift amount of 0 means: no shift for kind 00; a result of zero for kind 01; every bit equal to bit 31 of `reg_off` for kind 10; for kind 11 a one-bit right rotate through carry, with `carry_in` entering bit 31.
- R9: Outputs update on the clock edge where `in_valid` is 1 and hold their value while `in_valid` is 0; `out_valid` equals the value `in_valid` had at the previous edge.
- R10: After reset `out_valid`, `wb_en` and `force_user` are 0 and `xfer_addr` and `new_base` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Capture the current request |
| base_val | input | 32 | Base register value |
| use_reg | input | 1 | 1: register offset, 0: immediate offset |
| imm_off | input | 12 | Unsigned immediate offset |
| reg_off | input | 32 | Offset register value |
| shift_ctl | input | 7 | [6:2] shift amount, [1:0] shift kind |
| carry_in | input | 1 | Carry flag used by the rotate-through-carry case |
| up | input | 1 | 1: add offset, 0: subtract offset |
| pre | input | 1 | 1: pre-indexed, 0: post-indexed |
| wb | input | 1 | Writeback request flag |
| priv | input | 1 | Request issued in privileged mode |
| out_valid | output | 1 | Registered results are valid |
| xfer_addr | output | 32 | Address for the memory transfer |
| new_base | output | 32 | Value for the base register |
| wb_en | output | 1 | Base register is to be written |
| force_user | output | 1 | Transfer must be treated as non-privileged |

## Verification
Writeback and forced-user access can both happen on the same post-indexed request. That case also has the transfer address differ from the written base. The bench drives post-indexed requests with `wb` and `priv` both set. It runs them under subtraction and under the rotate-through-carry offset. On the cycle after each request it compares `xfer_addr`, `new_base`, `wb_en` and `force_user` together against a model. Random requests mix all flag combinations with every shift kind, including amount 0, so the two functions meet again under varied operands.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

   localparam int unsigned SHAMT_W = 5;

   typedef enum logic [1:0] {
      SH_LSL = 2'b00,
      SH_LSR = 2'b01,
      SH_ASR = 2'b10,
      SH_ROR = 2'b11
   } shift_kind_e;

   typedef struct packed {
      logic [SHAMT_W-1:0] amt;
      shift_kind_e        kind;
   } shift_ctl_t;

endpackage

// File: rtl/lsag_shifter.sv
module lsag_shifter
   import lsag_pkg::*;
#(
   parameter int unsigned W     = 32,
   parameter int unsigned AMT_W = SHAMT_W
) (
   input  logic [W-1:0]     din,
   input  logic [AMT_W-1:0] amt,
   input  shift_kind_e      kind,
   input  logic             carry_in,
   output logic [W-1:0]     dout
);

   localparam int unsigned DW = 2 * W;

   logic [DW-1:0] doubled;
   logic [DW-1:0] rot_wide;
   logic          amt_zero;

   assign doubled  = {din, din};
   assign rot_wide = doubled >> amt;
   assign amt_zero = (amt == '0);

   always_comb begin
      unique case (kind)
         SH_LSL: dout = din << amt;
         SH_LSR: dout = amt_zero ? '0 : (din >> amt);
         SH_ASR: dout = amt_zero ? {W{din[W-1]}} : W'($signed(din) >>> amt);
         default: dout = amt_zero ? {carry_in, din[W-1:1]} : rot_wide[W-1:0];
      endcase
   end

endmodule

// File: rtl/lsag_offset_sel.sv
module lsag_offset_sel #(
   parameter int unsigned W     = 32,
   parameter int unsigned IMM_W = 12
) (
   input  logic             use_reg,
   input  logic [IMM_W-1:0] imm,
   input  logic [W-1:0]     shifted,
   output logic [W-1:0]     offset
);

   localparam int unsigned PAD_W = W - IMM_W;

   logic [W-1:0] imm_ext;

   assign imm_ext = {{PAD_W{1'b0}}, imm};
   assign offset  = use_reg ? shifted : imm_ext;

endmodule

// File: rtl/lsag_addr_calc.sv
module lsag_addr_calc #(
   parameter int unsigned W            = 32,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic [W-1:0] base,
   input  logic [W-1:0] offset,
   input  logic         up,
   input  logic         pre,
   input  logic         wb,
   input  logic         priv,
   output logic [W-1:0] addr,
   output logic [W-1:0] base_next,
   output logic         wb_en,
   output logic         force_user
);

   logic [W-1:0] adjusted;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [W-1:0] operand;
         logic [W-1:0] cin_vec;
         assign operand  = offset ^ {W{~up}};
         assign cin_vec  = {{(W-1){1'b0}}, ~up};
         assign adjusted = base + operand + cin_vec;
      end else begin : g_split
         logic [W-1:0] sum;
         logic [W-1:0] diff;
         assign sum      = base + offset;
         assign diff     = base - offset;
         assign adjusted = up ? sum : diff;
      end
   endgenerate

   assign wb_en      = ~pre | wb;
   assign addr       = pre ? adjusted : base;
   assign base_next  = wb_en ? adjusted : base;
   assign force_user = ~pre & wb & priv;

endmodule

// File: rtl/lsag_top.sv
module lsag_top
   import lsag_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned IMM_W        = 12,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [DATA_W-1:0]             base_val,
   input  logic                          use_reg,
   input  logic [IMM_W-1:0]              imm_off,
   input  logic [DATA_W-1:0]             reg_off,
   input  logic [SHAMT_W+1:0]            shift_ctl,
   input  logic                          carry_in,
   input  logic                          up,
   input  logic                          pre,
   input  logic                          wb,
   input  logic                          priv,
   output logic                          out_valid,
   output logic [DATA_W-1:0]             xfer_addr,
   output logic [DATA_W-1:0]             new_base,
   output logic                          wb_en,
   output logic                          force_user
);

   localparam int unsigned FULL_SHIFT = 1 << SHAMT_W;

   generate
      if (FULL_SHIFT != DATA_W) begin : g_bad_width
         $error("lsag_top: DATA_W must equal 2**SHAMT_W");
      end
      if (IMM_W == 0 || IMM_W >= DATA_W) begin : g_bad_imm
         $error("lsag_top: IMM_W must lie between 1 and DATA_W-1");
      end
   endgenerate

   shift_ctl_t          sctl;
   logic [DATA_W-1:0]   shifted;
   logic [DATA_W-1:0]   offset;
   logic [DATA_W-1:0]   addr_c;
   logic [DATA_W-1:0]   base_c;
   logic                wb_en_c;
   logic                fu_c;

   assign sctl = shift_ctl_t'(shift_ctl);

   lsag_shifter #(
      .W     (DATA_W),
      .AMT_W (SHAMT_W)
   ) u_shift (
      .din      (reg_off),
      .amt      (sctl.amt),
      .kind     (sctl.kind),
      .carry_in (carry_in),
      .dout     (shifted)
   );

   lsag_offset_sel #(
      .W     (DATA_W),
      .IMM_W (IMM_W)
   ) u_osel (
      .use_reg (use_reg),
      .imm     (imm_off),
      .shifted (shifted),
      .offset  (offset)
   );

   lsag_addr_calc #(
      .W            (DATA_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_calc (
      .base       (base_val),
      .offset     (offset),
      .up         (up),
      .pre        (pre),
      .wb         (wb),
      .priv       (priv),
      .addr       (addr_c),
      .base_next  (base_c),
      .wb_en      (wb_en_c),
      .force_user (fu_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         xfer_addr  <= '0;
         new_base   <= '0;
         wb_en      <= 1'b0;
         force_user <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            xfer_addr  <= addr_c;
            new_base   <= base_c;
            wb_en      <= wb_en_c;
            force_user <= fu_c;
         end
      end
   end

endmodule

// File: rtl/lsag_top_chk.sv
module lsag_top_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] base_val,
   input logic              use_reg,
   input logic [IMM_W-1:0]  imm_off,
   input logic              up,
   input logic              pre,
   input logic              wb,
   input logic              priv,
   input logic              out_valid,
   input logic [DATA_W-1:0] xfer_addr,
   input logic [DATA_W-1:0] new_base,
   input logic              wb_en,
   input logic              force_user
);

   // R9
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R3
   post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !pre) |=> (xfer_addr == $past(base_val)));

   // R5
   post_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !pre) |=> wb_en);

   // R4
   pre_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pre && !wb) |=> (!wb_en && new_base == $past(base_val)));

   // R6
   force_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (force_user == ($past(!pre) && $past(wb) && $past(priv))));

   // R1
   imm_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !use_reg && up && pre) |=>
         (xfer_addr == $past(base_val) + DATA_W'($past(imm_off))));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(xfer_addr) && $stable(new_base) && $stable(wb_en)));

endmodule

bind lsag_top lsag_top_chk #(
   .DATA_W (DATA_W),
   .IMM_W  (IMM_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .base_val   (base_val),
   .use_reg    (use_reg),
   .imm_off    (imm_off),
   .up         (up),
   .pre        (pre),
   .wb         (wb),
   .priv       (priv),
   .out_valid  (out_valid),
   .xfer_addr  (xfer_addr),
   .new_base   (new_base),
   .wb_en      (wb_en),
   .force_user (force_user)
);

// File: tb/lsag_top_test.sv
`timescale 1ns/1ps
module lsag_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] base_val = '0;
   logic        use_reg = 1'b0;
   logic [11:0] imm_off = '0;
   logic [31:0] reg_off = '0;
   logic [6:0]  shift_ctl = '0;
   logic        carry_in = 1'b0;
   logic        up = 1'b0, pre = 1'b0, wb = 1'b0, priv = 1'b0;
   logic        out_valid, wb_en, force_user;
   logic [31:0] xfer_addr, new_base;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lsag_top uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
      .use_reg(use_reg), .imm_off(imm_off), .reg_off(reg_off),
      .shift_ctl(shift_ctl), .carry_in(carry_in), .up(up), .pre(pre),
      .wb(wb), .priv(priv), .out_valid(out_valid), .xfer_addr(xfer_addr),
      .new_base(new_base), .wb_en(wb_en), .force_user(force_user)
   );

   // Model of the register-offset shift (R7, R8), written with bit loops
   function automatic logic [31:0] m_shift(input logic [31:0] x, input logic [4:0] a,
                                           input logic [1:0] k, input logic c);
      logic [31:0] r;
      r = x;
      if (a == 0) begin
         case (k)
            2'd0: r = x;
            2'd1: r = 32'd0;
            2'd2: r = x[31] ? 32'hFFFF_FFFF : 32'd0;
            default: r = {c, x[31:1]};
         endcase
      end else begin
         for (int i = 0; i < int'(a); i++) begin
            case (k)
               2'd0: r = {r[30:0], 1'b0};
               2'd1: r = {1'b0, r[31:1]};
               2'd2: r = {r[31], r[31:1]};
               default: r = {r[0], r[31:1]};
            endcase
         end
      end
      return r;
   endfunction

   task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one request at the falling edge, check after the next rising edge
   task automatic issue(input logic [31:0] b, input logic ur, input logic [11:0] im,
                        input logic [31:0] ro, input logic [6:0] sc, input logic ci,
                        input logic u, input logic p, input logic w, input logic pv,
                        input string tag);
      logic [31:0] off, adj, e_addr, e_base;
      logic        e_wb, e_fu;
      @(negedge clk);
      in_valid = 1'b1; base_val = b; use_reg = ur; imm_off = im; reg_off = ro;
      shift_ctl = sc; carry_in = ci; up = u; pre = p; wb = w; priv = pv;
      off    = ur ? m_shift(ro, sc[6:2], sc[1:0], ci) : {20'd0, im};
      adj    = u ? b + off : b - off;
      e_addr = p ? adj : b;
      e_wb   = !p || w;
      e_base = e_wb ? adj : b;
      e_fu   = !p && w && pv;
      @(negedge clk);
      in_valid = 1'b0;
      cmp({tag, " R9 out_valid"}, {31'd0, out_valid}, 32'd1);
      cmp({tag, " R2 R3 xfer_addr"}, xfer_addr, e_addr);
      cmp({tag, " R4 R5 new_base"}, new_base, e_base);
      cmp({tag, " R4 R5 wb_en"}, {31'd0, wb_en}, {31'd0, e_wb});
      cmp({tag, " R6 force_user"}, {31'd0, force_user}, {31'd0, e_fu});
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] hold_a, hold_b;
      process::self().srandom(32'h5EED_0042);
      repeat (3) @(negedge clk);
      // R10 reset state
      cmp("R10 out_valid", {31'd0, out_valid}, 32'd0);
      cmp("R10 xfer_addr", xfer_addr, 32'd0);
      cmp("R10 new_base", new_base, 32'd0);
      cmp("R10 wb_en/force_user", {30'd0, wb_en, force_user}, 32'd0);
      rst_n = 1'b1;

      // R1 R2 immediate add and subtract, pre-indexed
      issue(32'h0000_1000, 0, 12'hFFF, 0, 0, 0, 1, 1, 1, 0, "R1 imm add");
      issue(32'h0000_0004, 0, 12'h010, 0, 0, 0, 0, 1, 0, 0, "R2 sub wrap");
      issue(32'hFFFF_FFF0, 0, 12'h020, 0, 0, 0, 1, 1, 1, 0, "R2 add wrap");
      // R3 R5 post-indexed, W ignored for writeback
      issue(32'h8000_0000, 0, 12'h004, 0, 0, 0, 1, 0, 0, 1, "R5 post w0");
      // R6 post + W + priv: writeback and forced user together
      issue(32'h2000_0000, 1, 0, 32'h0000_0081, {5'd0, 2'b11}, 1, 0, 0, 1, 1, "R6 R8 rrx sub");
      issue(32'h2000_0000, 0, 12'h100, 0, 0, 0, 0, 0, 1, 1, "R6 post sub");
      issue(32'h2000_0000, 0, 12'h100, 0, 0, 0, 0, 0, 1, 0, "R6 unpriv");
      issue(32'h2000_0000, 0, 12'h100, 0, 0, 0, 0, 1, 1, 1, "R6 pre priv");
      // R7 shift kinds
      issue(32'h1000, 1, 0, 32'h0000_0003, {5'd4, 2'b00}, 0, 1, 1, 0, 0, "R7 lsl");
      issue(32'h1000, 1, 0, 32'h8000_0000, {5'd31, 2'b01}, 0, 1, 1, 0, 0, "R7 lsr");
      issue(32'h1000, 1, 0, 32'h8000_0000, {5'd4, 2'b10}, 0, 1, 1, 0, 0, "R7 asr");
      issue(32'h1000, 1, 0, 32'h0000_000F, {5'd4, 2'b11}, 0, 1, 1, 0, 0, "R7 ror");
      // R8 zero-amount cases
      issue(32'h1000, 1, 0, 32'h1234_5678, {5'd0, 2'b00}, 1, 1, 1, 0, 0, "R8 lsl0");
      issue(32'h1000, 1, 0, 32'hFFFF_FFFF, {5'd0, 2'b01}, 1, 1, 1, 0, 0, "R8 lsr32");
      issue(32'h1000, 1, 0, 32'h8000_0000, {5'd0, 2'b10}, 0, 1, 1, 0, 0, "R8 asr32");
      issue(32'h1000, 1, 0, 32'h0000_0002, {5'd0, 2'b11}, 0, 1, 1, 0, 0, "R8 rrx c0");

      // R9 hold while in_valid is low
      hold_a = xfer_addr; hold_b = new_base;
      @(negedge clk);
      base_val = 32'hDEAD_BEEF; imm_off = 12'h555; pre = 1'b0; wb = 1'b1; priv = 1'b1;
      @(negedge clk);
      cmp("R9 hold out_valid", {31'd0, out_valid}, 32'd0);
      cmp("R9 hold xfer_addr", xfer_addr, hold_a);
      cmp("R9 hold new_base", new_base, hold_b);

      // Random mix
      for (int i = 0; i < 400; i++) begin
         issue($urandom, 1'($urandom), 12'($urandom), $urandom, 7'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               "R7 rand");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule